// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital receive side of a 12-bit serial-input converter. A host sends 16-bit words over three wires: an active-low select, a serial clock and a data line. The serial pins are brought into the system clock domain with two-flop synchronisers. A falling edge of the serial clock is detected in that domain, and on each one the data bit is shifted into an input register. An internal counter tracks the edges.

When the sixteenth edge arrives, the complete word moves into an input latch on its own, without waiting for select to rise. On the next cycle the upper four bits are decoded as a command. Only the all-zero command copies the lower twelve bits into the converter code register and pulses an update strobe. Every other command is a no-op. Once a word has completed, select has to go high and then low again before another word is taken.

Top module: `dac_serial_frontend`

## Requirements
- R1: After reset, `dacCode` is 0x000 and `dacUpdate` is low.
- R2: A frame is 16 bits sent most significant bit first. Bits 15..12 are the command and bits 11..0 are the code. Each bit is taken on a falling edge of `serSclk` while `serSelN` is low. A frame with command 0000 sets `dacCode` to its code field.
- R3: `dacUpdate` is high for exactly one system clock cycle each time `dacCode` is written. `dacCode` never changes in a cycle where `dacUpdate` is low.
- R4: A frame whose command is not 0000 leaves `dacCode` unchanged and raises no `dacUpdate`.
- R5: If `serSelN` rises before sixteen falling edges, the partial frame is discarded and the next frame is received from its first bit.
- R6: Falling edges after the sixteenth, within the same low period of `serSelN`, are ignored. A new frame is accepted only after `serSelN` has gone high and then low again.
- R7: Serial clock edges while `serSelN` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serSclk | input | 1 | Serial clock, asynchronous to clk, idles high |
| serSdi | input | 1 | Serial data, most significant bit first |
| serSelN | input | 1 | Active-low frame select |
| dacCode | output | 12 | Code register that drives the converter |
| dacUpdate | output | 1 | One-cycle pulse when dacCode is written |

## Verification
The assertions assume the serial inputs are slow compared with `clk`. Each serial clock level and each data bit must hold for several system cycles, so that the synchronised falling edge sees settled data. Select must change only while the serial clock is high. The stimulus keeps four system cycles per serial half period and sets data a full half period before each falling edge. It moves select only with the serial clock idle, and leaves several cycles after release, so no frame can start before the previous decode has finished.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int CMD_W = 4;
  localparam int CODE_W = 12;
  localparam int FRAME_W = CMD_W + CODE_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic shiftEn;
    logic frameDone;
  } ctrl_strobes_t;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic sdiIn,
  input  logic selNIn,
  output logic sclkFall,
  output logic sdiSync,
  output logic selIdle
);
  logic [STAGES-1:0] sclkPipe, sdiPipe, selPipe;
  logic sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '1;
      sdiPipe  <= '0;
      selPipe  <= '1;
      sclkLast <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[STAGES-2:0], sclkIn};
      sdiPipe  <= {sdiPipe[STAGES-2:0], sdiIn};
      selPipe  <= {selPipe[STAGES-2:0], selNIn};
      sclkLast <= sclkPipe[STAGES-1];
    end
  end

  assign sclkFall = sclkLast & ~sclkPipe[STAGES-1];
  assign sdiSync  = sdiPipe[STAGES-1];
  assign selIdle  = selPipe[STAGES-1];
endmodule

// File: rtl/dac_fe_ctrl.sv
module dac_fe_ctrl
  import dac_fe_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkFall,
  input  logic          selIdle,
  output ctrl_strobes_t strobes
);
  logic [CNT_W-1:0] bitCnt;
  logic frameFull;

  assign frameFull         = (bitCnt == CNT_W'(FRAME_W));
  assign strobes.shiftEn   = sclkFall & ~selIdle & ~frameFull;
  assign strobes.frameDone = strobes.shiftEn & (bitCnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCnt <= '0;
    else if (selIdle)         bitCnt <= '0;
    else if (strobes.shiftEn) bitCnt <= bitCnt + 1'b1;
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));
  assert_no_shift_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    selIdle |-> !strobes.shiftEn);
  assert_clear_on_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    selIdle |=> bitCnt == '0);
  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameFull && !selIdle) |=> bitCnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/dac_fe_datapath.sv
module dac_fe_datapath
  import dac_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic              sdiBit,
  output logic [CODE_W-1:0] codeReg,
  output logic              codeStb
);
  logic [FRAME_W-1:0] shiftReg, inLatch;
  logic decodePend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      inLatch    <= '0;
      decodePend <= 1'b0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], sdiBit};
      if (strobes.frameDone) inLatch <= {shiftReg[FRAME_W-2:0], sdiBit};
      decodePend <= strobes.frameDone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
      codeStb <= 1'b0;
    end else begin
      codeStb <= 1'b0;
      if (decodePend && inLatch[FRAME_W-1 -: CMD_W] == '0) begin
        codeReg <= inLatch[CODE_W-1:0];
        codeStb <= 1'b1;
      end
    end
  end

  assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    codeStb |=> !codeStb);
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !codeStb |-> $stable(codeReg));
  assert_noop_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (decodePend && inLatch[FRAME_W-1 -: CMD_W] != '0) |=> !codeStb);
  assert_stb_after_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    codeStb |-> $past(decodePend));
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
  import dac_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serSclk,
  input  logic              serSdi,
  input  logic              serSelN,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacUpdate
);
  logic sclkFall, sdiSync, selIdle;
  ctrl_strobes_t strobes;

  dac_fe_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclkIn(serSclk), .sdiIn(serSdi), .selNIn(serSelN),
    .sclkFall(sclkFall), .sdiSync(sdiSync), .selIdle(selIdle)
  );

  dac_fe_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclkFall(sclkFall), .selIdle(selIdle), .strobes(strobes)
  );

  dac_fe_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiBit(sdiSync),
    .codeReg(dacCode), .codeStb(dacUpdate)
  );
endmodule

// File: tb/tb_dac_serial_frontend.sv
module tb_dac_serial_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serSclk = 1'b1, serSdi = 1'b0, serSelN = 1'b1;
  logic [11:0] dacCode;
  logic dacUpdate;

  int tests = 0, fails = 0;
  logic [11:0] expQ[$];
  logic lastUpd = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_frontend dut (
    .clk(clk), .rstN(rstN), .serSclk(serSclk), .serSdi(serSdi), .serSelN(serSelN),
    .dacCode(dacCode), .dacUpdate(dacUpdate)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sendBits(input logic [15:0] w, input int n);
    serSelN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < n; i++) begin
      serSdi = w[15-i];
      waitClk(HALF);
      serSclk = 1'b0;
      waitClk(HALF);
      serSclk = 1'b1;
    end
    waitClk(HALF);
  endtask

  task automatic releaseSel();
    serSelN = 1'b1;
    waitClk(8);
  endtask

  task automatic frame(input logic [15:0] w);
    if (w[15:12] == 4'h0) expQ.push_back(w[11:0]);
    sendBits(w, 16);
    releaseSel();
  endtask

  task automatic checkCode(input logic [11:0] exp, input string req);
    @(negedge clk);
    tests++;
    if (dacCode !== exp) begin
      fails++;
      $display("FAIL %s dacCode actual=%h expected=%h", req, dacCode, exp);
    end
  endtask

  // Monitor / scoreboard (R2, R3)
  always @(negedge clk) begin
    if (rstN) begin
      if (dacUpdate) begin
        tests++;
        if (lastUpd) begin
          fails++;
          $display("FAIL R3 strobe wider than one cycle actual=1 expected=0");
        end else if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R3 unexpected strobe code actual=%h expected=none", dacCode);
        end else begin
          logic [11:0] e;
          e = expQ.pop_front();
          if (dacCode !== e) begin
            fails++;
            $display("FAIL R2 loaded code actual=%h expected=%h", dacCode, e);
          end
        end
      end
      lastUpd = dacUpdate;
    end
  end

  initial begin
    waitClk(200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    @(negedge clk);
    tests++;
    if (dacCode !== 12'h000 || dacUpdate !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=000/0", dacCode, dacUpdate);
    end
    rstN = 1'b1;
    waitClk(4);

    // R2: plain loads
    frame(16'h0ABC); checkCode(12'hABC, "R2");
    frame(16'h0FFF); checkCode(12'hFFF, "R2");
    frame(16'h0000); checkCode(12'h000, "R2");
    frame(16'h0555); checkCode(12'h555, "R2");

    // R4: non-zero commands are no-ops
    frame(16'h5123); checkCode(12'h555, "R4");
    frame(16'h8FFF); checkCode(12'h555, "R4");
    frame(16'h1000); checkCode(12'h555, "R4");

    // R5: partial frames discarded
    sendBits(16'h0777, 9); releaseSel();
    checkCode(12'h555, "R5");
    sendBits(16'h0ABD, 15); releaseSel();
    checkCode(12'h555, "R5");
    frame(16'h0321); checkCode(12'h321, "R5");

    // R6: extra edges in the same select period are ignored
    expQ.push_back(12'h246);
    sendBits(16'h0246, 16);
    sendBits(16'h0FFF, 16);
    sendBits(16'h0ACE, 5);
    releaseSel();
    checkCode(12'h246, "R6");
    frame(16'h0987); checkCode(12'h987, "R6");

    // R7: clock toggling with select high
    for (int i = 0; i < 20; i++) begin
      serSdi = i[0];
      waitClk(HALF); serSclk = 1'b0;
      waitClk(HALF); serSclk = 1'b1;
    end
    waitClk(8);
    checkCode(12'h987, "R7");
    frame(16'h0135); checkCode(12'h135, "R7");

    waitClk(10);
    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R3 missing strobes actual=%0d pending expected=0", expQ.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule